// File: doc/BRIEF.md
# Backplane Command Slave with Parity-Gated Read-Back

This block is the slave end of a parallel crate backplane bus that uses a strobe and acknowledge handshake. The master sets an 8-bit board address, a 16-bit data word, a read/write flag and one odd-parity bit for each of address and data. It then raises the strobe. Every slave samples the bus, but only the board whose address matches raises the acknowledge. The master then drops the strobe, and the slave drops the acknowledge once it sees the strobe low.

A write cycle carries a command word. The low five bits are the command code and the upper eleven bits are the argument. If both parity bits are correct and the code is one the board knows, the block hands the command to local logic as a one-cycle strobe with the code and argument. It also remembers the word as the last accepted command. A following read cycle to the same board is answered only when that last command was accepted. The answer drives the stored word and its parity onto the return data lines. If the slave stays silent on the read-back, the command was refused and never executed.

All bus inputs pass through a two-flop synchroniser before use. A transaction starts only on a rising edge of the synchronised strobe.

Top module: `bpl_cmd_slave`

## Requirements
- R1: After reset, `bus_ack`, `bus_data_oe` and `cmd_stb` are 0, and no command counts as accepted, so a read-back to the own address gets no acknowledge.
- R2: Parity is odd. An address is good when the 8 address bits and `bus_addr_par` hold an odd number of ones. A data word is good when the 16 data bits and `bus_data_par` hold an odd number of ones.
- R3: Only a cycle whose `bus_addr` equals `BOARD_ADDR` can be acknowledged. Cycles to any other address give no acknowledge and no command strobe, and they leave the last accepted command unchanged.
- R4: Once raised, `bus_ack` stays high while the strobe is high. It falls within 8 clock cycles after the strobe goes low.
- R5: A write (`bus_rd`=0) to the own address with good address and data parity and a known code is acknowledged. A code is known when `data[4:0]` is in 1..`NUM_CMDS`-1, which is 1..23 by default. The write gives exactly one `cmd_stb` pulse with `cmd_code` = `data[4:0]` and `cmd_arg` = `data[15:5]`.
- R6: A write to the own address with good address parity and bad data parity is acknowledged. It gives no `cmd_stb`, and it clears the accepted state, so the next read-back gets no acknowledge.
- R7: A write to the own address with good parities and an unknown code is acknowledged, but it gives no `cmd_stb` and it clears the accepted state. An unknown code is 0 or a value of `NUM_CMDS` or above.
- R8: A read (`bus_rd`=1) to the own address with good address parity, after an accepted command, is acknowledged. During the acknowledge, `bus_data_oe`=1, `bus_data_out` equals the accepted word, and `bus_data_par_out` gives that word odd parity.
- R9: A cycle to the own address with bad address parity gets no acknowledge and no `cmd_stb`, and it clears the accepted state.
- R10: A read-back does not change the accepted state, so repeated read-backs return the same word.
- R11: One strobe pulse is one transaction. Holding the strobe high for many cycles gives at most one `cmd_stb` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Board address field from the backplane |
| bus_addr_par | input | 1 | Odd parity bit for the address |
| bus_data | input | 16 | Command word from the backplane |
| bus_data_par | input | 1 | Odd parity bit for the command word |
| bus_rd | input | 1 | 1 = read-back cycle, 0 = write cycle |
| bus_stb | input | 1 | Master strobe, active high, asynchronous |
| bus_ack | output | 1 | Slave acknowledge, active high |
| bus_data_out | output | 16 | Read-back word |
| bus_data_par_out | output | 1 | Odd parity bit for the read-back word |
| bus_data_oe | output | 1 | Enable for the slave's return data drivers |
| cmd_stb | output | 1 | One-cycle pulse for an accepted command |
| cmd_code | output | 5 | Code of the accepted command |
| cmd_arg | output | 11 | Argument of the accepted command |

## Verification
The assertions assume the master sets the address, data, direction and parity before it raises the strobe. They also assume the master holds them stable until the strobe falls, so the synchronised fields and the synchronised strobe line up when a rising edge is captured. The bench keeps within this: it changes the bus fields only while the strobe is low, a full clock before raising it. It holds the strobe high for a fixed window and waits for the acknowledge to clear before starting the next cycle. The parity sweeps, code sweeps and address sweeps all run inside this handshake.

// File: rtl/bpl_cmd_slave_pkg.sv
package bpl_cmd_slave_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_EVAL = 2'd1,
    HS_HOLD = 2'd2
  } hs_state_e;

  localparam int SYNC_DEPTH = 2;

endpackage

// File: rtl/bpl_in_sync.sv
module bpl_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bpl_frame_check.sv
module bpl_frame_check #(
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 16,
  parameter int              CODE_W     = 5,
  parameter int              NUM_CMDS   = 24,
  parameter logic [ADDR_W-1:0] BOARD_ADDR = 8'h5A
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_par,
  input  logic [DATA_W-1:0] data,
  input  logic              data_par,
  output logic              addr_hit,
  output logic              addr_par_ok,
  output logic              data_par_ok,
  output logic              code_known
);

  localparam logic [CODE_W:0] CODE_LIM = NUM_CMDS[CODE_W:0];

  logic [CODE_W-1:0] code;

  always_comb begin
    code        = data[CODE_W-1:0];
    addr_hit    = (addr == BOARD_ADDR);
    addr_par_ok = ^{addr, addr_par};
    data_par_ok = ^{data, data_par};
    code_known  = (code != '0) && ({1'b0, code} < CODE_LIM);
  end

endmodule

// File: rtl/bpl_cmd_slave.sv
module bpl_cmd_slave
  import bpl_cmd_slave_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 16,
  parameter int                CODE_W     = 5,
  parameter int                NUM_CMDS   = 24,
  parameter logic [ADDR_W-1:0] BOARD_ADDR = 8'h5A
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_addr_par,
  input  logic [DATA_W-1:0]        bus_data,
  input  logic                     bus_data_par,
  input  logic                     bus_rd,
  input  logic                     bus_stb,
  output logic                     bus_ack,
  output logic [DATA_W-1:0]        bus_data_out,
  output logic                     bus_data_par_out,
  output logic                     bus_data_oe,
  output logic                     cmd_stb,
  output logic [CODE_W-1:0]        cmd_code,
  output logic [DATA_W-CODE_W-1:0] cmd_arg
);

  localparam int BUS_W = ADDR_W + DATA_W + 4;

  // synchronised bus fields
  logic [BUS_W-1:0]  bus_raw, bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic              apar_s, dpar_s, rd_s, stb_s;
  logic [DATA_W-1:0] data_s;
  logic              stb_d, stb_rise;

  assign bus_raw = {bus_addr, bus_addr_par, bus_data, bus_data_par, bus_rd, bus_stb};

  bpl_in_sync #(.W(BUS_W), .STAGES(SYNC_DEPTH)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (bus_raw),
    .q   (bus_s)
  );

  assign {addr_s, apar_s, data_s, dpar_s, rd_s, stb_s} = bus_s;

  always_ff @(posedge clk) begin
    if (rst) stb_d <= 1'b0;
    else     stb_d <= stb_s;
  end

  assign stb_rise = stb_s & ~stb_d;

  // captured frame
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_apar, cap_dpar, cap_rd;
  logic [DATA_W-1:0] cap_data;
  logic              hit, apar_ok, dpar_ok, known;

  bpl_frame_check #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
    .NUM_CMDS(NUM_CMDS), .BOARD_ADDR(BOARD_ADDR)
  ) chk_i (
    .addr        (cap_addr),
    .addr_par    (cap_apar),
    .data        (cap_data),
    .data_par    (cap_dpar),
    .addr_hit    (hit),
    .addr_par_ok (apar_ok),
    .data_par_ok (dpar_ok),
    .code_known  (known)
  );

  // handshake state machine
  hs_state_e         state;
  logic              last_ok;
  logic [DATA_W-1:0] last_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      state            <= HS_IDLE;
      cap_addr         <= '0;
      cap_apar         <= 1'b0;
      cap_data         <= '0;
      cap_dpar         <= 1'b0;
      cap_rd           <= 1'b0;
      last_ok          <= 1'b0;
      last_word        <= '0;
      bus_ack          <= 1'b0;
      bus_data_oe      <= 1'b0;
      bus_data_out     <= '0;
      bus_data_par_out <= 1'b0;
      cmd_stb          <= 1'b0;
      cmd_code         <= '0;
      cmd_arg          <= '0;
    end else begin
      cmd_stb <= 1'b0;
      unique case (state)
        HS_IDLE: begin
          if (stb_rise) begin
            cap_addr <= addr_s;
            cap_apar <= apar_s;
            cap_data <= data_s;
            cap_dpar <= dpar_s;
            cap_rd   <= rd_s;
            state    <= HS_EVAL;
          end
        end
        HS_EVAL: begin
          state <= HS_IDLE;
          if (hit) begin
            if (!apar_ok) begin
              last_ok <= 1'b0;
            end else if (cap_rd) begin
              if (last_ok) begin
                bus_ack          <= 1'b1;
                bus_data_oe      <= 1'b1;
                bus_data_out     <= last_word;
                bus_data_par_out <= ~^last_word;
                state            <= HS_HOLD;
              end
            end else begin
              bus_ack <= 1'b1;
              state   <= HS_HOLD;
              if (dpar_ok && known) begin
                last_ok   <= 1'b1;
                last_word <= cap_data;
                cmd_stb   <= 1'b1;
                cmd_code  <= cap_data[CODE_W-1:0];
                cmd_arg   <= cap_data[DATA_W-1:CODE_W];
              end else begin
                last_ok <= 1'b0;
              end
            end
          end
        end
        HS_HOLD: begin
          if (!stb_s) begin
            bus_ack     <= 1'b0;
            bus_data_oe <= 1'b0;
            state       <= HS_IDLE;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && stb_s) |=> bus_ack);

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack) |-> !$past(stb_s));

  // R3
  ack_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack) |-> (cap_addr == BOARD_ADDR));

  // R11
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !cmd_stb);

  // R5
  cmd_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> bus_ack);

  // R8
  rb_oe_chk: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe |-> bus_ack);

  // R8
  rb_par_chk: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe |-> (^{bus_data_out, bus_data_par_out}));

endmodule

// File: tb/bpl_cmd_slave_tb.sv
module bpl_cmd_slave_tb_top;

  localparam logic [7:0] OWN = 8'h5A;
  localparam int NCMD = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_addr_par = 1'b0;
  logic [15:0] bus_data = '0;
  logic        bus_data_par = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_stb = 1'b0;
  logic        bus_ack, bus_data_par_out, bus_data_oe, cmd_stb;
  logic [15:0] bus_data_out;
  logic [4:0]  cmd_code;
  logic [10:0] cmd_arg;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bpl_cmd_slave dut_i (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_addr_par(bus_addr_par),
    .bus_data(bus_data), .bus_data_par(bus_data_par),
    .bus_rd(bus_rd), .bus_stb(bus_stb),
    .bus_ack(bus_ack), .bus_data_out(bus_data_out),
    .bus_data_par_out(bus_data_par_out), .bus_data_oe(bus_data_oe),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_arg(cmd_arg)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic opar8(input logic [7:0] v);
    return ~^v;
  endfunction

  function automatic logic opar16(input logic [15:0] v);
    return ~^v;
  endfunction

  // one handshake; returns what was seen at the ports
  int          r_ack, r_cmd, r_rel, r_drop;
  logic [4:0]  r_code;
  logic [10:0] r_arg;
  logic [15:0] r_dat;
  logic        r_par;

  task automatic cyc(input logic [7:0] a, input bit bad_ap, input bit rd,
                     input logic [15:0] d, input bit bad_dp);
    r_ack = 0; r_cmd = 0; r_rel = 0; r_drop = 0;
    r_code = '0; r_arg = '0; r_dat = '0; r_par = 1'b0;
    @(negedge clk);
    bus_addr     = a;
    bus_addr_par = opar8(a) ^ bad_ap;
    bus_data     = d;
    bus_data_par = opar16(d) ^ bad_dp;
    bus_rd       = rd;
    @(negedge clk);
    bus_stb = 1'b1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (bus_ack) begin
        r_ack++;
        if (bus_data_oe) begin r_dat = bus_data_out; r_par = bus_data_par_out; end
      end else if (r_ack != 0) r_drop = 1;
      if (cmd_stb) begin r_cmd++; r_code = cmd_code; r_arg = cmd_arg; end
    end
    bus_stb = 1'b0;
    for (int i = 0; i < 8; i++) @(negedge clk);
    r_rel = (bus_ack == 1'b0 && bus_data_oe == 1'b0) ? 1 : 0;
    bus_addr = '0; bus_data = '0; bus_rd = 1'b0;
    bus_addr_par = 1'b0; bus_data_par = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_rb(input string req, input bit want, input logic [15:0] w);
    cyc(OWN, 1'b0, 1'b1, 16'h0000, 1'b0);
    chk((r_ack != 0) == want, req, "read-back ack", r_ack != 0, want);
    if (want) begin
      chk(r_dat == w, req, "read-back word", r_dat, w);
      chk(r_par == opar16(w), req, "read-back parity", r_par, opar16(w));
      chk(r_drop == 0, "R4", "ack held during strobe", r_drop, 0);
    end
    chk(r_rel == 1, "R4", "ack released", r_rel, 1);
  endtask

  initial begin
    #(150000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [15:0] keep;
    int  amiss;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bus_ack == 1'b0, "R1", "ack after reset", bus_ack, 0);
    chk(bus_data_oe == 1'b0, "R1", "oe after reset", bus_data_oe, 0);
    chk(cmd_stb == 1'b0, "R1", "cmd_stb after reset", cmd_stb, 0);
    expect_rb("R1", 1'b0, 16'h0);

    // R5 R7 R10 R11: sweep every code
    for (int c = 0; c < 32; c++) begin
      logic [10:0] arg;
      bit known;
      arg   = 11'(c * 37 + 5);
      w     = {arg, 5'(c)};
      known = (c != 0) && (c < NCMD);
      cyc(OWN, 1'b0, 1'b0, w, 1'b0);
      chk(r_ack != 0, known ? "R5" : "R7", "write ack", r_ack != 0, 1);
      chk(r_cmd == (known ? 1 : 0), known ? "R11" : "R7", "cmd_stb pulses",
          r_cmd, known ? 1 : 0);
      if (known) begin
        chk(r_code == 5'(c), "R5", "cmd_code", r_code, c);
        chk(r_arg == arg, "R5", "cmd_arg", r_arg, arg);
      end
      chk(r_rel == 1, "R4", "write ack released", r_rel, 1);
      expect_rb(known ? "R8" : "R7", known, w);
      if (known) expect_rb("R10", 1'b1, w);
    end

    // R6 data parity error
    w = {11'h2A5, 5'd9};
    cyc(OWN, 1'b0, 1'b0, w, 1'b0);
    expect_rb("R6", 1'b1, w);
    cyc(OWN, 1'b0, 1'b0, {11'h111, 5'd4}, 1'b1);
    chk(r_ack != 0, "R6", "bad data parity ack", r_ack != 0, 1);
    chk(r_cmd == 0, "R6", "bad data parity cmd", r_cmd, 0);
    expect_rb("R6", 1'b0, 16'h0);

    // R9 R2 address parity error, write and read
    w = {11'h0F3, 5'd17};
    cyc(OWN, 1'b0, 1'b0, w, 1'b0);
    expect_rb("R2", 1'b1, w);
    cyc(OWN, 1'b1, 1'b0, {11'h00C, 5'd2}, 1'b0);
    chk(r_ack == 0, "R9", "bad addr parity ack", r_ack, 0);
    chk(r_cmd == 0, "R9", "bad addr parity cmd", r_cmd, 0);
    expect_rb("R9", 1'b0, 16'h0);
    cyc(OWN, 1'b0, 1'b0, w, 1'b0);
    cyc(OWN, 1'b1, 1'b1, 16'h0, 1'b0);
    chk(r_ack == 0, "R9", "bad addr parity read ack", r_ack, 0);
    expect_rb("R9", 1'b0, 16'h0);

    // R3 address sweep: writes and reads to every foreign address
    keep = {11'h5C3, 5'd21};
    cyc(OWN, 1'b0, 1'b0, keep, 1'b0);
    amiss = 0;
    for (int a = 0; a < 256; a++) begin
      if (8'(a) == OWN) continue;
      cyc(8'(a), 1'b0, 1'b0, {11'(a), 5'd3}, 1'b0);
      if (r_ack != 0 || r_cmd != 0) amiss++;
      if ((a % 16) == 3) begin
        cyc(8'(a), 1'b0, 1'b1, 16'h0, 1'b0);
        if (r_ack != 0) amiss++;
      end
    end
    chk(amiss == 0, "R3", "foreign address responses", amiss, 0);
    expect_rb("R3", 1'b1, keep);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule